// File: doc/BRIEF.md
# Machine-Cycle State Sequencer

This block steps a small 8-bit processor core through its machine cycles. A normal instruction takes a fetch cycle and then an execute cycle. Some instructions take a second execute cycle. The current cycle type is driven onto a two-bit state code. At each instruction boundary the sequencer decides between three paths. It can insert memory-read cycles for a display-style DMA consumer. It can insert a single interrupt-response cycle. Otherwise it starts the next fetch.

During a DMA cycle the block places its DMA pointer on the address bus, asserts a memory read and then advances the pointer by one. During an interrupt-response cycle it saves the current X and P register indices into a temporary register T, forces P and X to fixed service values, and clears the interrupt-enable flag. A return operation, signalled during an execute cycle, restores X and P from a supplied byte and sets the enable flag again. The instruction decoder is outside this block. A small configurable stub stands in for it and reports which opcodes need the second execute cycle.

Top module: `mcyc_sequencer`

## Requirements
- R1: The state code is 2'b00 for fetch, 2'b01 for execute, 2'b10 for DMA and 2'b11 for interrupt response. Reset puts the block in fetch with IE=1, P=0, X=0, T=0 and the DMA pointer at 0, even if a request is held.
- R2: With no request pending, an instruction is one fetch cycle followed by one execute cycle, and then the next fetch cycle.
- R3: An opcode whose upper four bits are 4'hC, present during the fetch cycle, is followed by two execute cycles instead of one.
- R4: Both request inputs are active low. They are acted on only in the final execute cycle of an instruction, or in a DMA cycle. A request held during a fetch cycle or during the first execute cycle of a long instruction does not cut in.
- R5: In each DMA cycle, mem_rd is 1 and mem_addr equals the DMA pointer. The pointer then increases by one, so successive DMA cycles read consecutive addresses.
- R6: DMA cycles follow one another for as long as the DMA request stays low. When the request is released, the sequencer proceeds to interrupt response or to fetch.
- R7: An interrupt request is taken only while IE is 1. While IE is 0 the request has no effect, and the instruction boundary goes to fetch.
- R8: An interrupt-response cycle loads T with {X,P} (X in bits 7:4), sets P=1 and X=2, and clears IE. The following cycle is always a fetch, whatever the requests are.
- R9: When DMA and interrupt requests are both pending at a boundary, DMA cycles come first. The interrupt-response cycle follows directly after the last DMA cycle.
- R10: ret_req high during an execute cycle sets X=ret_t[7:4], P=ret_t[3:0] and IE=1 at the end of that cycle. That boundary still arbitrates with the IE value the cycle started with.
- R11: Outside DMA cycles, mem_rd is 0 and mem_addr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Interrupt request, active low |
| dma_req_n | input | 1 | DMA-out request, active low |
| opcode | input | 8 | Instruction byte, valid during fetch |
| ret_req | input | 1 | Return operation, valid during execute |
| ret_t | input | 8 | Saved {X,P} to restore on return |
| state_code | output | 2 | Current machine-cycle state code |
| mem_rd | output | 1 | Memory read strobe for DMA |
| mem_addr | output | 16 | DMA address (zero outside DMA) |
| p_idx | output | 4 | Program-counter register index P |
| x_idx | output | 4 | Indirect register index X |
| t_reg | output | 8 | Temporary register T = {X,P} |
| ie | output | 1 | Interrupt-enable flag |

## Verification
Requests, opcode and return inputs are read at the rising edge that ends the current cycle. Their effect therefore appears in the state code and registers exactly one cycle later. A request applied during the final execute cycle produces a DMA or interrupt-response code in the next cycle. Register changes made by an interrupt-response or return cycle become visible in the cycle that follows it. The bench drives each row of inputs at a falling edge and checks the outputs at that same falling edge, before the new inputs take effect. Each row's expected state is therefore the consequence of the previous row's inputs. The DMA addresses are predicted by counting the DMA cycles seen since reset.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   // Machine-cycle state; the encoding is the externally visible state code.
   typedef enum logic [1:0] {
      ST_FETCH = 2'b00,
      ST_EXEC  = 2'b01,
      ST_DMA   = 2'b10,
      ST_INTR  = 2'b11
   } mcyc_state_e;

   // Long-instruction decode variants of the stub.
   localparam int LONG_NONE   = 0;
   localparam int LONG_MASKED = 1;

endpackage

// File: rtl/mcyc_decode_stub.sv
module mcyc_decode_stub #(
   parameter int                 OPC_W      = 8,
   parameter int                 LONG_MODE  = 1,
   parameter logic [OPC_W-1:0]   LONG_MASK  = 8'hF0,
   parameter logic [OPC_W-1:0]   LONG_MATCH = 8'hC0
) (
   input  logic [OPC_W-1:0] opcode,
   output logic             needs_extra
);
   import mcyc_pkg::*;

   if (OPC_W < 4) begin : g_bad_width
      $error("mcyc_decode_stub: OPC_W must be at least 4");
   end
   if (LONG_MODE != LONG_NONE && LONG_MODE != LONG_MASKED) begin : g_bad_mode
      $error("mcyc_decode_stub: unsupported LONG_MODE");
   end

   if (LONG_MODE == LONG_MASKED) begin : g_masked
      assign needs_extra = ((opcode & LONG_MASK) == LONG_MATCH);
   end else begin : g_none
      logic unused_opc;
      assign unused_opc  = ^opcode;
      assign needs_extra = 1'b0 & unused_opc;
   end

endmodule

// File: rtl/mcyc_arbiter.sv
module mcyc_arbiter (
   input  mcyc_pkg::mcyc_state_e state,
   input  logic                  extra_left,
   input  logic                  dma_req,
   input  logic                  irq_req,
   input  logic                  ie,
   output mcyc_pkg::mcyc_state_e next_state
);
   import mcyc_pkg::*;

   logic boundary;
   logic take_irq;

   // A boundary is the last execute cycle or any DMA cycle.
   assign boundary = ((state == ST_EXEC) && !extra_left) || (state == ST_DMA);
   assign take_irq = irq_req && ie;

   always_comb begin
      next_state = ST_FETCH;
      unique case (state)
         ST_FETCH: next_state = ST_EXEC;
         ST_EXEC, ST_DMA: begin
            if (!boundary)       next_state = ST_EXEC;
            else if (dma_req)    next_state = ST_DMA;
            else if (take_irq)   next_state = ST_INTR;
            else                 next_state = ST_FETCH;
         end
         ST_INTR:  next_state = ST_FETCH;
         default:  next_state = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcyc_dma_ptr.sv
module mcyc_dma_ptr #(
   parameter int                  ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]   PTR_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_cycle,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("mcyc_dma_ptr: ADDR_W must be at least 8");
   end

   logic [ADDR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q <= PTR_RESET;
      else if (dma_cycle) ptr_q <= ptr_q + 1'b1;
   end

   assign mem_addr = dma_cycle ? ptr_q : '0;
   assign mem_rd   = dma_cycle;

   // R5: pointer advances by exactly one after every DMA cycle
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      dma_cycle |=> (ptr_q == $past(ptr_q) + 1'b1));

   // R5: pointer holds outside DMA cycles
   a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_cycle |=> $stable(ptr_q));

endmodule

// File: rtl/mcyc_ctx_regs.sv
module mcyc_ctx_regs #(
   parameter int IDX_W  = 4,
   parameter int INTR_P = 1,
   parameter int INTR_X = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               intr_cycle,
   input  logic               ret_fire,
   input  logic [2*IDX_W-1:0] ret_t,
   output logic [IDX_W-1:0]   p_idx,
   output logic [IDX_W-1:0]   x_idx,
   output logic [2*IDX_W-1:0] t_reg,
   output logic               ie
);

   localparam int NREG = 1 << IDX_W;

   if (IDX_W < 2) begin : g_bad_idx
      $error("mcyc_ctx_regs: IDX_W must be at least 2");
   end
   if (INTR_P >= NREG || INTR_X >= NREG) begin : g_bad_vec
      $error("mcyc_ctx_regs: service indices exceed register file");
   end

   localparam logic [IDX_W-1:0] P_SVC = IDX_W'(INTR_P);
   localparam logic [IDX_W-1:0] X_SVC = IDX_W'(INTR_X);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_idx <= '0;
         x_idx <= '0;
         t_reg <= '0;
         ie    <= 1'b1;
      end else if (intr_cycle) begin
         t_reg <= {x_idx, p_idx};
         p_idx <= P_SVC;
         x_idx <= X_SVC;
         ie    <= 1'b0;
      end else if (ret_fire) begin
         x_idx <= ret_t[2*IDX_W-1:IDX_W];
         p_idx <= ret_t[IDX_W-1:0];
         ie    <= 1'b1;
      end
   end

   // R8: service entry saves context and redirects
   a_r8_ctx_save: assert property (@(posedge clk) disable iff (!rst_n)
      intr_cycle |=> (t_reg == $past({x_idx, p_idx})) && (p_idx == P_SVC)
                     && (x_idx == X_SVC) && !ie);

   // R10: return restores indices and re-enables
   a_r10_return: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_fire && !intr_cycle) |=> ({x_idx, p_idx} == $past(ret_t)) && ie);

endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer #(
   parameter int                ADDR_W     = 16,
   parameter int                IDX_W      = 4,
   parameter int                OPC_W      = 8,
   parameter int                LONG_MODE  = 1,
   parameter logic [OPC_W-1:0]  LONG_MASK  = 8'hF0,
   parameter logic [OPC_W-1:0]  LONG_MATCH = 8'hC0,
   parameter int                INTR_P     = 1,
   parameter int                INTR_X     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 irq_n,
   input  logic                 dma_req_n,
   input  logic [OPC_W-1:0]     opcode,
   input  logic                 ret_req,
   input  logic [2*IDX_W-1:0]   ret_t,
   output logic [1:0]           state_code,
   output logic                 mem_rd,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [IDX_W-1:0]     p_idx,
   output logic [IDX_W-1:0]     x_idx,
   output logic [2*IDX_W-1:0]   t_reg,
   output logic                 ie
);
   import mcyc_pkg::*;

   mcyc_state_e state_q, state_d;
   logic        extra_q;
   logic        needs_extra;
   logic        dma_req, irq_req;
   logic        ret_fire;

   assign dma_req  = !dma_req_n;
   assign irq_req  = !irq_n;
   assign ret_fire = ret_req && (state_q == ST_EXEC);

   mcyc_decode_stub #(
      .OPC_W      (OPC_W),
      .LONG_MODE  (LONG_MODE),
      .LONG_MASK  (LONG_MASK),
      .LONG_MATCH (LONG_MATCH)
   ) u_decode (
      .opcode      (opcode),
      .needs_extra (needs_extra)
   );

   mcyc_arbiter u_arb (
      .state      (state_q),
      .extra_left (extra_q),
      .dma_req    (dma_req),
      .irq_req    (irq_req),
      .ie         (ie),
      .next_state (state_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         extra_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_FETCH)     extra_q <= needs_extra;
         else if (state_q == ST_EXEC) extra_q <= 1'b0;
      end
   end

   mcyc_dma_ptr #(
      .ADDR_W (ADDR_W)
   ) u_dma (
      .clk       (clk),
      .rst_n     (rst_n),
      .dma_cycle (state_q == ST_DMA),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd)
   );

   mcyc_ctx_regs #(
      .IDX_W  (IDX_W),
      .INTR_P (INTR_P),
      .INTR_X (INTR_X)
   ) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .intr_cycle (state_q == ST_INTR),
      .ret_fire   (ret_fire),
      .ret_t      (ret_t),
      .p_idx      (p_idx),
      .x_idx      (x_idx),
      .t_reg      (t_reg),
      .ie         (ie)
   );

   assign state_code = state_q;

   // R2: a fetch is always followed by an execute
   a_r2_fetch_exec: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH) |=> (state_q == ST_EXEC));

   // R3: a long instruction stays in execute for one more cycle
   a_r3_long_exec: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && extra_q) |=> (state_q == ST_EXEC));

   // R6: DMA continues while the request is held
   a_r6_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DMA && !dma_req_n) |=> (state_q == ST_DMA));

   // R7: interrupt response only when enabled in the previous cycle
   a_r7_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INTR) |-> $past(ie));

   // R8: interrupt response lasts one cycle and returns to fetch
   a_r8_intr_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INTR) |=> (state_q == ST_FETCH));

   // R9: a boundary with DMA pending enters DMA regardless of interrupts
   a_r9_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && !extra_q && !dma_req_n) |=> (state_q == ST_DMA));

endmodule

// File: tb/mcyc_sequencer_test.sv
module mcyc_sequencer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       irq_n = 1'b1;
   logic       dma_req_n = 1'b1;
   logic [7:0] opcode = 8'h00;
   logic       ret_req = 1'b0;
   logic [7:0] ret_t = 8'h00;
   logic [1:0] state_code;
   logic       mem_rd;
   logic [15:0] mem_addr;
   logic [3:0] p_idx, x_idx;
   logic [7:0] t_reg;
   logic       ie;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 4 ns period

   mcyc_sequencer uut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .dma_req_n(dma_req_n),
      .opcode(opcode), .ret_req(ret_req), .ret_t(ret_t),
      .state_code(state_code), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .p_idx(p_idx), .x_idx(x_idx), .t_reg(t_reg), .ie(ie)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Row: {irq_n, dma_req_n, opcode[7:0], ret_req, ret_t[7:0], exp_state[1:0], req[3:0]}
   // exp_state is the code seen in the row's own cycle (caused by earlier rows).
   localparam int NROW = 21;
   localparam logic [24:0] VEC [NROW] = '{
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b00,4'd1 },  // 0  R1 fetch after reset
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b01,4'd2 },  // 1  R2 execute
      {1'b1,1'b1,8'hC4,1'b0,8'h00,2'b00,4'd2 },  // 2  R2 fetch of long opcode
      {1'b1,1'b0,8'h00,1'b0,8'h00,2'b01,4'd3 },  // 3  R3 first exec, DMA held
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b01,4'd3 },  // 4  R3 second exec
      {1'b1,1'b0,8'h00,1'b0,8'h00,2'b00,4'd4 },  // 5  R4 DMA during fetch
      {1'b1,1'b0,8'h00,1'b0,8'h00,2'b01,4'd4 },  // 6  R4 still no cut-in
      {1'b1,1'b0,8'h00,1'b0,8'h00,2'b10,4'd5 },  // 7  R5 first DMA
      {1'b0,1'b0,8'h00,1'b0,8'h00,2'b10,4'd6 },  // 8  R6 DMA repeats, IRQ joins
      {1'b0,1'b1,8'h00,1'b0,8'h00,2'b10,4'd6 },  // 9  R6 last DMA
      {1'b0,1'b0,8'h00,1'b0,8'h00,2'b11,4'd9 },  // 10 R9 IRQ after burst
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b00,4'd8 },  // 11 R8 fetch follows
      {1'b0,1'b1,8'h00,1'b0,8'h00,2'b01,4'd7 },  // 12 R7 IRQ while IE=0
      {1'b0,1'b1,8'h00,1'b0,8'h00,2'b00,4'd7 },  // 13 R7 ignored
      {1'b0,1'b1,8'h00,1'b1,8'h5A,2'b01,4'd7 },  // 14 R7 return here, old IE=0
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b00,4'd10},  // 15 R10 fetch, not interrupt
      {1'b0,1'b1,8'h00,1'b0,8'h00,2'b01,4'd10},  // 16 R10 IRQ now enabled
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b11,4'd7 },  // 17 R7 taken
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b00,4'd8 },  // 18 R8 fetch
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b01,4'd2 },  // 19 R2
      {1'b1,1'b1,8'h00,1'b0,8'h00,2'b00,4'd2 }   // 20 R2
   };

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      int dma_seen;
      dma_seen = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "reset state_code", 32'(state_code), 32'h0);
      chk("R1", "reset ie", 32'(ie), 32'h1);
      chk("R1", "reset P", 32'(p_idx), 32'h0);
      chk("R1", "reset X", 32'(x_idx), 32'h0);
      chk("R1", "reset T", 32'(t_reg), 32'h0);
      chk("R11", "reset mem_rd", 32'(mem_rd), 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NROW; i++) begin
         chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("row %0d state", i),
             32'(state_code), 32'(VEC[i][5:4]));
         if (VEC[i][5:4] == 2'b10) begin
            // R5: consecutive addresses from zero
            chk("R5", $sformatf("row %0d mem_rd", i), 32'(mem_rd), 32'h1);
            chk("R5", $sformatf("row %0d mem_addr", i), 32'(mem_addr), 32'(dma_seen));
            dma_seen++;
         end else begin
            // R11: idle bus outside DMA
            chk("R11", $sformatf("row %0d bus idle", i),
                32'({mem_rd, mem_addr}), 32'h0);
         end
         if (i == 11) begin
            chk("R8", "T after first interrupt", 32'(t_reg), 32'h00);
            chk("R8", "P/X after interrupt", 32'({x_idx, p_idx}), 32'h21);
            chk("R8", "ie cleared", 32'(ie), 32'h0);
         end
         if (i == 15) begin
            chk("R10", "X/P restored", 32'({x_idx, p_idx}), 32'h5A);
            chk("R10", "ie set", 32'(ie), 32'h1);
         end
         if (i == 18) begin
            chk("R8", "T saves {X,P}", 32'(t_reg), 32'h5A);
            chk("R8", "P/X forced", 32'({x_idx, p_idx}), 32'h21);
            chk("R8", "ie cleared again", 32'(ie), 32'h0);
         end
         irq_n     = VEC[i][24];
         dma_req_n = VEC[i][23];
         opcode    = VEC[i][22:15];
         ret_req   = VEC[i][14];
         ret_t     = VEC[i][13:6];
         @(posedge clk);
         @(negedge clk);
      end

      // R1: reset during a held DMA request returns to fetch, pointer cleared
      irq_n = 1'b1; dma_req_n = 1'b0; ret_req = 1'b0; opcode = 8'h00;
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R1", "reset with DMA held", 32'(state_code), 32'h0);
      chk("R1", "ie after reset", 32'(ie), 32'h1);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R4", "exec after reset, DMA held", 32'(state_code), 32'h1);
      @(posedge clk); @(negedge clk);
      chk("R5", "DMA entered", 32'(state_code), 32'h2);
      chk("R5", "pointer restarts at zero", 32'(mem_addr), 32'h0);
      @(posedge clk); @(negedge clk);
      chk("R5", "second DMA address", 32'(mem_addr), 32'h1);
      dma_req_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R6", "release ends burst", 32'(state_code), 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule